// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block is the fetch side of a transmit DMA. It follows a ring of two-word descriptors held in memory, reads the buffer each descriptor points at, and sends the bytes out one per beat. Consecutive buffers are joined into one frame until a buffer flagged as the frame's final one has been drained. When a frame is complete, the engine writes status back into the frame's opening descriptor so that software can reclaim every buffer of that frame.

Software ends a chain by placing a descriptor whose ownership (used) bit is already set after the last real descriptor. If the engine meets that bit between frames, it stops quietly. If it meets the bit inside a frame, the buffers ran out early: the engine closes the stream with an error beat and flags exhaustion. The byte sink does not apply backpressure. If it is not ready when a byte is due, that is an underrun, and the frame is closed in the same way.

Top module: `tx_ring_dma`

## Requirements
- R1: Descriptor layout. Word 0 at offset 0 holds the buffer byte address. Word 1 at offset 4 holds the length in bits 10:0, end-of-frame in bit 15, wrap in bit 30 and used in bit 31. A one-cycle `start_i` while `ctrl_en_i` is high starts fetching at `qbase_i`.
- R2: Buffer bytes leave in ascending address order. Within a 32-bit memory word the lowest byte address is in bits 7:0, and a buffer may start at any byte offset. Each beat carries one byte. Buffers are joined until one with bit 15 set, and `tx_last_o` marks that buffer's final byte.
- R3: A descriptor fetched with bit 31 set while no frame is open stops the engine. `busy_o` falls and no error is flagged.
- R4: After a descriptor with bit 30 set, the next fetch is at `qbase_i`. Otherwise the next fetch is at the current descriptor address plus 8.
- R5: On frame completion, word 1 of the frame's first descriptor is written back with bit 31 set, bits 28 and 27 cleared and all other bits as fetched. Later descriptors of the frame are not written. `frame_done_o` pulses for one cycle after the write.
- R6: A descriptor with bit 31 set met inside a frame causes four things. One error beat is sent (`tx_valid_o`, `tx_last_o` and `tx_err_o` high, data 0). Word 1 of the first descriptor is written back with bits 31 and 27 set. `exhausted_o` is set and the engine halts. The flag holds until the next accepted start.
- R7: If `tx_ready_i` is low in a cycle where a byte is due, the byte is not sent. The engine sends the error beat, writes back with bits 31 and 28 set, sets `underrun_o` and halts. Data beats without `tx_err_o` occur only with `tx_ready_i` high.
- R8: A `start_i` pulse while `busy_o` is high is ignored. No fetch restarts, the frame continues unchanged and the flags are not cleared.
- R9: While `ctrl_en_i` is low, no memory access and no beat occurs. A running engine returns to idle at the next clock and does no write-back. A start is ignored while `ctrl_en_i` is low.
- R10: After reset the engine is idle. `busy_o`, `tx_valid_o`, `mem_rd_o`, `mem_wr_o` and both error flags are low.
- R11: Memory read data is taken in the cycle after `mem_rd_o`. Read addresses are word-aligned, and a read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_en_i | input | 1 | Transmit enable |
| start_i | input | 1 | Start pulse |
| qbase_i | input | AW | Ring base byte address |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_rdata_i | input | 32 | Read data, one cycle after request |
| tx_valid_o | output | 1 | Stream beat present |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final beat of frame |
| tx_err_o | output | 1 | Beat closes an aborted frame |
| tx_ready_i | input | 1 | Sink can take a byte |
| busy_o | output | 1 | Engine not idle |
| frame_done_o | output | 1 | One-cycle pulse per completed frame |
| exhausted_o | output | 1 | Sticky: ring ended mid-frame |
| underrun_o | output | 1 | Sticky: sink not ready for a due byte |

## Verification
The assertions check, on every cycle, the port-level rules:
- aligned, exclusive memory accesses;
- silence while idle or disabled;
- data beats only with the sink ready;
- every error beat also ending the frame;
- every write-back carrying the used bit;
- a done pulse following a write;
- sticky flags surviving a start that arrives while busy.

Other behaviour can only be shown by the bench's scenarios. This covers byte order across unaligned word boundaries, buffer concatenation, wrap to the base, the exact write-back words, and the abort paths for ring exhaustion and underrun.

// File: rtl/tx_ring_pkg.sv
`timescale 1ns/1ps
package tx_ring_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 11;
  localparam int BIT_USED = 31;
  localparam int BIT_WRAP = 30;
  localparam int BIT_UNDR = 28;
  localparam int BIT_EXH  = 27;
  localparam int BIT_EOF  = 15;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_DEC, ST_DRD, ST_DLAT, ST_DOUT, ST_NEXT, ST_ERR, ST_WB
  } eng_st_e;

  typedef struct packed {
    logic             used;
    logic             wrap;
    logic             eof;
    logic [LEN_W-1:0] len;
  } desc_ctl_t;
endpackage

// File: rtl/tx_desc_decode.sv
`timescale 1ns/1ps
module tx_desc_decode
  import tx_ring_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output desc_ctl_t         ctl_o,
  output logic [WORD_W-1:0] clean_o
);
  always_comb begin
    ctl_o.used = word_i[BIT_USED];
    ctl_o.wrap = word_i[BIT_WRAP];
    ctl_o.eof  = word_i[BIT_EOF];
    ctl_o.len  = word_i[LEN_W-1:0];
    // stale ownership and error bits from an earlier pass are dropped
    clean_o = word_i;
    clean_o[BIT_USED] = 1'b0;
    clean_o[BIT_UNDR] = 1'b0;
    clean_o[BIT_EXH]  = 1'b0;
  end
endmodule

// File: rtl/tx_byte_lane.sv
`timescale 1ns/1ps
module tx_byte_lane #(
  parameter int WORD_W = 32,
  localparam int NB     = WORD_W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [7:0]        byte_o
);
  logic [WORD_W-1:0] word_q;
  logic [7:0]        lanes [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = word_q[g*8 +: 8];
  end

  assign byte_o = lanes[lane_i];
endmodule

// File: rtl/tx_ring_dma.sv
`timescale 1ns/1ps
module tx_ring_dma
  import tx_ring_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_en_i,
  input  logic              start_i,
  input  logic [AW-1:0]     qbase_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  output logic              tx_err_o,
  input  logic              tx_ready_i,
  output logic              busy_o,
  output logic              frame_done_o,
  output logic              exhausted_o,
  output logic              underrun_o
);
  localparam int NB         = WORD_W / 8;
  localparam int LANE_W     = $clog2(NB);
  localparam int DESC_BYTES = 2 * NB;

  eng_st_e           state_q;
  logic [AW-1:0]     ptr_q, first_ptr_q, buf_q;
  logic [WORD_W-1:0] first_w1_q, wb_q;
  logic [LEN_W-1:0]  rem_q;
  logic              eof_q, wrap_q, in_frame_q, exh_q, und_q, done_q;

  desc_ctl_t         dec;
  logic [WORD_W-1:0] dec_clean;
  logic [7:0]        lane_byte;
  logic [AW-1:0]     next_ptr;
  logic              rd_c, wr_c, v_c, l_c, e_c;
  logic [AW-1:0]     a_c;
  logic [WORD_W-1:0] wd_c;

  tx_desc_decode u_dec (
    .word_i (mem_rdata_i),
    .ctl_o  (dec),
    .clean_o(dec_clean)
  );

  tx_byte_lane #(.WORD_W(WORD_W)) u_lane (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(state_q == ST_DLAT),
    .word_i(mem_rdata_i),
    .lane_i(buf_q[LANE_W-1:0]),
    .byte_o(lane_byte)
  );

  assign next_ptr = wrap_q ? qbase_i : ptr_q + AW'(DESC_BYTES);

  always_comb begin
    rd_c = 1'b0; wr_c = 1'b0; a_c = '0; wd_c = '0;
    v_c  = 1'b0; l_c  = 1'b0; e_c = 1'b0;
    case (state_q)
      ST_RD0:  begin rd_c = 1'b1; a_c = ptr_q; end
      ST_RD1:  begin rd_c = 1'b1; a_c = ptr_q + AW'(NB); end
      ST_DRD:  begin rd_c = 1'b1; a_c = {buf_q[AW-1:LANE_W], {LANE_W{1'b0}}}; end
      ST_DOUT: begin v_c = tx_ready_i; l_c = eof_q && (rem_q == LEN_W'(1)); end
      ST_ERR:  begin v_c = 1'b1; l_c = 1'b1; e_c = 1'b1; end
      ST_WB:   begin wr_c = 1'b1; a_c = first_ptr_q + AW'(NB); wd_c = wb_q; end
      default: ;
    endcase
  end

  // everything at the edge is held off while transmit is disabled
  assign mem_rd_o     = rd_c && ctrl_en_i;
  assign mem_wr_o     = wr_c && ctrl_en_i;
  assign mem_addr_o   = ctrl_en_i ? a_c : '0;
  assign mem_wdata_o  = ctrl_en_i ? wd_c : '0;
  assign tx_valid_o   = v_c && ctrl_en_i;
  assign tx_last_o    = l_c && tx_valid_o;
  assign tx_err_o     = e_c && tx_valid_o;
  assign tx_data_o    = (tx_valid_o && !e_c) ? lane_byte : 8'h00;
  assign busy_o       = state_q != ST_IDLE;
  assign frame_done_o = done_q;
  assign exhausted_o  = exh_q;
  assign underrun_o   = und_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ptr_q       <= '0;
      first_ptr_q <= '0;
      buf_q       <= '0;
      first_w1_q  <= '0;
      wb_q        <= '0;
      rem_q       <= '0;
      eof_q       <= 1'b0;
      wrap_q      <= 1'b0;
      in_frame_q  <= 1'b0;
      exh_q       <= 1'b0;
      und_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!ctrl_en_i && state_q != ST_IDLE) begin
        state_q    <= ST_IDLE;
        in_frame_q <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: if (start_i && ctrl_en_i) begin
            ptr_q      <= qbase_i;
            exh_q      <= 1'b0;
            und_q      <= 1'b0;
            in_frame_q <= 1'b0;
            state_q    <= ST_RD0;
          end
          ST_RD0: state_q <= ST_RD1;
          ST_RD1: begin
            buf_q   <= mem_rdata_i[AW-1:0];
            state_q <= ST_DEC;
          end
          ST_DEC: begin
            if (dec.used) begin
              if (in_frame_q) begin
                exh_q   <= 1'b1;
                wb_q    <= first_w1_q | (WORD_W'(1) << BIT_USED) | (WORD_W'(1) << BIT_EXH);
                state_q <= ST_ERR;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              rem_q  <= dec.len;
              eof_q  <= dec.eof;
              wrap_q <= dec.wrap;
              if (!in_frame_q) begin
                first_ptr_q <= ptr_q;
                first_w1_q  <= dec_clean;
                in_frame_q  <= 1'b1;
              end
              state_q <= (dec.len == '0) ? ST_NEXT : ST_DRD;
            end
          end
          ST_DRD:  state_q <= ST_DLAT;
          ST_DLAT: state_q <= ST_DOUT;
          ST_DOUT: begin
            if (!tx_ready_i) begin
              und_q   <= 1'b1;
              wb_q    <= first_w1_q | (WORD_W'(1) << BIT_USED) | (WORD_W'(1) << BIT_UNDR);
              state_q <= ST_ERR;
            end else begin
              buf_q <= buf_q + AW'(1);
              rem_q <= rem_q - LEN_W'(1);
              if (rem_q == LEN_W'(1))        state_q <= ST_NEXT;
              else if (&buf_q[LANE_W-1:0])   state_q <= ST_DRD;
            end
          end
          ST_NEXT: begin
            if (eof_q) begin
              wb_q    <= first_w1_q | (WORD_W'(1) << BIT_USED);
              state_q <= ST_WB;
            end else begin
              ptr_q   <= next_ptr;
              state_q <= ST_RD0;
            end
          end
          ST_ERR: state_q <= ST_WB;
          ST_WB: begin
            in_frame_q <= 1'b0;
            if (exh_q || und_q) begin
              state_q <= ST_IDLE;
            end else begin
              ptr_q   <= next_ptr;
              done_q  <= 1'b1;
              state_q <= ST_RD0;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_RD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> mem_addr_o[LANE_W-1:0] == '0);                              // R11
  AST_RDWR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));                                                // R11
  AST_BEAT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_err_o) |-> tx_ready_i);                               // R7
  AST_ERR_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_err_o) |-> tx_last_o);                                 // R6
  AST_WB_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> mem_wdata_o[BIT_USED]);                                     // R5
  AST_DONE_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(mem_wr_o));                                       // R5
  AST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_i |-> !(tx_valid_o || mem_rd_o || mem_wr_o));                   // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(tx_valid_o || mem_rd_o || mem_wr_o));                      // R3
  AST_EXH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exhausted_o && (busy_o || !start_i)) |=> exhausted_o);                  // R8
  AST_UND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && (busy_o || !start_i)) |=> underrun_o);                    // R8
endmodule

// File: tb/sim_tx_ring_dma.sv
`timescale 1ns/1ps
module sim_tx_ring_dma;
  localparam int QB = 32'h100;
  localparam logic [31:0] USED = 32'h8000_0000;
  localparam logic [31:0] WRAP = 32'h4000_0000;
  localparam logic [31:0] UNDR = 32'h1000_0000;
  localparam logic [31:0] EXH  = 32'h0800_0000;
  localparam logic [31:0] EOF  = 32'h0000_8000;
  localparam int NV = 5;
  localparam int VOFF [NV] = '{0, 0, 1, 3, 2};
  localparam int VLEN [NV] = '{1, 4, 6, 9, 2};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, start = 1'b0, ready = 1'b1;
  logic mem_rd, mem_wr, tx_valid, tx_last, tx_err, busy, fdone, exh, und;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data;
  logic [31:0] mem [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_a = '0;
  logic [31:0] poke_d = '0;

  int checks = 0, errors = 0, nbeat = 0, ndone = 0;
  logic [7:0] bd [1024];
  logic       bl [1024];
  logic       be [1024];
  int  exp_addr [64];
  logic exp_last [64];
  int  n_exp;

  always #10 clk = ~clk;

  tx_ring_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_en_i(en), .start_i(start), .qbase_i(32'(QB)),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .tx_err_o(tx_err), .tx_ready_i(ready), .busy_o(busy), .frame_done_o(fdone),
    .exhausted_o(exh), .underrun_o(und)
  );

  always @(posedge clk) begin
    if (poke_en)     mem[poke_a] <= poke_d;
    else if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
  end

  always @(negedge clk) begin
    if (tx_valid && nbeat < 1024) begin
      bd[nbeat] = tx_data; bl[nbeat] = tx_last; be[nbeat] = tx_err;
      nbeat = nbeat + 1;
    end
    if (fdone) ndone = ndone + 1;
  end

  function automatic logic [7:0] pat(int a);
    return 8'(a * 13 + 7);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic poke(int addr, logic [31:0] d);
    poke_a = addr[9:2]; poke_d = d; poke_en = 1'b1;
    @(posedge clk); #1 poke_en = 1'b0;
  endtask

  task automatic set_desc(int idx, int a, logic [31:0] w1);
    poke(QB + 8 * idx, 32'(a));
    poke(QB + 8 * idx + 4, w1);
  endtask

  function automatic logic [31:0] w1_of(int idx);
    return mem[(QB + 8 * idx + 4) >> 2];
  endfunction

  task automatic start_pulse();
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  task automatic wait_idle(string req);
    bit seen = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (!busy) begin seen = 1'b1; break; end
    end
    check(seen, req, 0, 1);
  endtask

  task automatic add_exp(int a, int n, bit eof_end);
    for (int i = 0; i < n; i++) begin
      exp_addr[n_exp] = a + i;
      exp_last[n_exp] = eof_end && (i == n - 1);
      n_exp++;
    end
  endtask

  task automatic compare(string req, int base);
    int bad = 0;
    check(nbeat - base == n_exp, req, nbeat - base, n_exp);
    for (int i = 0; i < n_exp && i < nbeat - base; i++)
      if (bd[base+i] !== pat(exp_addr[i]) || bl[base+i] !== exp_last[i] || be[base+i] !== 1'b0)
        bad++;
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base, d0, nb;
    for (int w = 128; w < 256; w++) begin
      poke(w * 4, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
    end
    @(negedge clk);
    // R10 reset state
    check(!busy && !tx_valid, "R10 idle", busy, 0);
    check(!mem_rd && !mem_wr, "R10 mem", mem_rd, 0);
    check(!exh && !und, "R10 flags", exh, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !fdone, "R10 after release", busy, 0);

    // table: single-buffer frames at varied offsets (R1 R2 R5)
    for (int v = 0; v < NV; v++) begin
      set_desc(0, 32'h200 + 16 * v + VOFF[v], 32'(VLEN[v]) | EOF);
      set_desc(1, 0, USED);
      base = nbeat; d0 = ndone; n_exp = 0;
      add_exp(32'h200 + 16 * v + VOFF[v], VLEN[v], 1'b1);
      start_pulse();
      wait_idle("R1 vector idle");
      compare("R2 vector bytes", base);
      check(w1_of(0) == (32'(VLEN[v]) | EOF | USED), "R5 vector writeback", w1_of(0), 32'(VLEN[v]) | EOF | USED);
      check(ndone - d0 == 1, "R5 vector done", ndone - d0, 1);
      check(!exh && !und, "R3 vector clean stop", exh, 0);
    end

    // R2 R5: two-buffer frame followed by a one-buffer frame
    set_desc(0, 32'h240, 32'd3);
    set_desc(1, 32'h251, 32'd5 | EOF);
    set_desc(2, 32'h260, 32'd2 | EOF);
    set_desc(3, 0, USED);
    base = nbeat; d0 = ndone; n_exp = 0;
    add_exp(32'h240, 3, 1'b0); add_exp(32'h251, 5, 1'b1); add_exp(32'h260, 2, 1'b1);
    start_pulse();
    wait_idle("R2 chain idle");
    compare("R2 chain bytes", base);
    check(ndone - d0 == 2, "R5 chain done", ndone - d0, 2);
    check(w1_of(0) == (32'd3 | USED), "R5 first desc", w1_of(0), 32'd3 | USED);
    check(w1_of(1) == (32'd5 | EOF), "R5 later desc untouched", w1_of(1), 32'd5 | EOF);
    check(w1_of(2) == (32'd2 | EOF | USED), "R5 second frame", w1_of(2), 32'd2 | EOF | USED);

    // R4 wrap: next fetch returns to base, finds its own used bit
    set_desc(0, 32'h280, 32'd2 | EOF | WRAP);
    set_desc(1, 32'h290, 32'd4 | EOF);
    set_desc(2, 0, USED);
    base = nbeat; n_exp = 0;
    add_exp(32'h280, 2, 1'b1);
    start_pulse();
    wait_idle("R4 idle");
    compare("R4 wrap bytes", base);
    check(w1_of(1) == (32'd4 | EOF), "R4 skipped desc", w1_of(1), 32'd4 | EOF);

    // R3 terminator at the head: nothing sent, no flag
    set_desc(0, 32'h200, USED | 32'd4 | EOF);
    base = nbeat;
    start_pulse();
    wait_idle("R3 idle");
    check(nbeat == base, "R3 no beats", nbeat - base, 0);
    check(!exh && !und, "R3 no flags", exh, 0);

    // R6 exhausted mid-frame
    set_desc(0, 32'h2a0, 32'd3);
    set_desc(1, 0, USED);
    base = nbeat; n_exp = 0;
    add_exp(32'h2a0, 3, 1'b0);
    start_pulse();
    wait_idle("R6 idle");
    check(nbeat - base == 4, "R6 beat count", nbeat - base, 4);
    check(be[base+3] && bl[base+3] && bd[base+3] == 8'h00, "R6 error beat", be[base+3], 1);
    nb = nbeat; nbeat = base + 3; compare("R6 data before abort", base); nbeat = nb;
    check(exh == 1'b1 && und == 1'b0, "R6 flag", exh, 1);
    check(w1_of(0) == (32'd3 | USED | EXH), "R6 writeback", w1_of(0), 32'd3 | USED | EXH);

    // R6 flag cleared by the next accepted start; R8 start while busy ignored
    set_desc(0, 32'h2c0, 32'd9 | EOF);
    set_desc(1, 0, USED);
    base = nbeat; d0 = ndone; n_exp = 0;
    add_exp(32'h2c0, 9, 1'b1);
    start_pulse();
    check(exh == 1'b0, "R6 cleared on start", exh, 0);
    wait (nbeat >= base + 3);
    start_pulse();
    wait_idle("R8 idle");
    compare("R8 frame unchanged", base);
    check(ndone - d0 == 1, "R8 single done", ndone - d0, 1);

    // R7 underrun
    set_desc(0, 32'h2e0, 32'd7 | EOF);
    set_desc(1, 0, USED);
    base = nbeat;
    start_pulse();
    wait (nbeat >= base + 2);
    @(posedge clk); #2 ready = 1'b0;
    wait_idle("R7 idle");
    ready = 1'b1;
    check(und == 1'b1 && exh == 1'b0, "R7 flag", und, 1);
    check(nbeat - base < 8 && be[nbeat-1] && bl[nbeat-1], "R7 error beat", nbeat - base, 3);
    check(w1_of(0) == (32'd7 | EOF | USED | UNDR), "R7 writeback", w1_of(0), 32'd7 | EOF | USED | UNDR);

    // R9 enable drop mid-frame, then start while disabled
    set_desc(0, 32'h300, 32'd20 | EOF);
    set_desc(1, 0, USED);
    base = nbeat;
    start_pulse();
    wait (nbeat >= base + 5);
    @(posedge clk); #2 en = 1'b0;
    nb = nbeat;
    repeat (3) @(negedge clk);
    check(!busy, "R9 idle after disable", busy, 0);
    check(nbeat == nb, "R9 no beats", nbeat - nb, 0);
    check(w1_of(0) == (32'd20 | EOF), "R9 no writeback", w1_of(0), 32'd20 | EOF);
    start_pulse();
    @(negedge clk);
    check(!busy, "R9 start ignored", busy, 1);
    en = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule